// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control front end of a common-I/O burst SRAM that is pipelined and organised in byte lanes. All of its controls are sampled on the rising clock edge. There are two address strobes, one for a processor and one for a controller, and three chip selects. It also takes a global write control, a byte write enable and one select per lane. From these inputs it opens accesses, steps a two-bit burst counter in linear or interleaved order, writes chosen lanes of an internal register-file array, and returns read data through an output register. That register drives the shared data bus only when the bus is safe to use.

The two strobes write with different latencies. A write opened by the controller strobe lands on the same edge. A write opened by the processor strobe lands one edge later, and its write controls are ignored on the opening edge. The processor strobe has no effect while the first chip select is inactive. The bus driver is held off in three cases: in the first cycle after the block leaves the deselected state, in the cycle that follows a deselecting edge, and whenever a write request is present on the inputs. The output enable input controls the driver only when none of these cases applies.

A small state machine tracks selection. ST_DESEL is the idle and deselected state. ST_PWAIT is entered after a processor-strobe opening, while the write window of that access is still pending. ST_ACTIVE is entered after any other opening and on every continuation. The transitions are:
- A selected strobe edge goes to ST_ACTIVE, or to ST_PWAIT if the strobe was the processor strobe.
- A strobe edge without full selection goes to ST_DESEL.
- An edge with no strobe in ST_PWAIT goes to ST_ACTIVE.
- Every other edge holds the current state.

Top module: `pburst_sram_ctrl`

## Requirements
- R1: The block is selected when cs1_n=0, cs2=1 and cs3_n=0 together. A valid strobe edge while selected opens an access at `addr`. A valid strobe edge while not selected deselects the block, and no array access happens on that edge.
- R2: While cs1_n=1, a low pstrb_n has no effect. If cstrb_n is high at the same time, the edge behaves as if no strobe were present.
- R3: An edge that accesses the array with no write request performs a read. The read word appears on rdata_out, with rdata_drive=1, during the cycle after the next edge, provided out_en_n=0 and nothing forces the driver off.
- R4: When an access is opened by pstrb_n, the write inputs and burst_adv_n are ignored on the opening edge. At the next edge with no strobe, the write request present at that edge writes the access address.
- R5: An access opened by cstrb_n=0 with pstrb_n inactive and a write request present writes the array on that same edge.
- R6: The write request selects lanes. With wr_all_n=0, all lanes are written, whatever wr_byte_n and lane_sel_n are. Otherwise, with wr_byte_n=0, each lane i whose lane_sel_n[i]=0 is written, where lane i is word bits [9i+8:9i]. Lanes that are not written keep their contents. A request that selects no lane counts as a read.
- R7: An edge with no strobe while not deselected is a continuation. If burst_adv_n=0 on it, the burst count increments first, wrapping from 3 to 0, and the edge then operates on the new address. The upper address bits come from the start address. The lower two bits are (start+count) mod 4 when burst_linear=1, and start XOR count when burst_linear=0.
- R8: A continuation edge with burst_adv_n=1 operates again on the current burst address.
- R9: In the cycle after an edge that opens an access from ST_DESEL, rdata_drive is 0 whatever out_en_n is.
- R10: In the cycle after a deselecting edge, rdata_drive is 0, even if a read was in flight.
- R11: rdata_drive is 0 in any cycle where a write request is present on the inputs, and in the cycle after any edge that wrote the array, whatever out_en_n is.
- R12: Reset returns the block to ST_DESEL, clears every array word to zero and holds rdata_drive at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pstrb_n | input | 1 | Processor address strobe, active low, gated by cs1_n |
| cstrb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low, on continuation edges |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| wr_all_n | input | 1 | Global write, active low, overrides lane controls |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable for the data driver, active low, asynchronous |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address sampled on an opening edge |
| wdata | input | LANES*LANE_W | Write data |
| rdata_out | output | LANES*LANE_W | Registered read data, zero while not driven |
| rdata_drive | output | 1 | Data driver enable (1 = driving) |

## Verification
The central collision is a read still moving through the output pipeline while a write or a deselect arrives in the same cycle. The bench provokes it in three ways: back-to-back reads followed at once by a write request, by a processor-strobe write whose second edge lands, or by a deselecting strobe. The behavioural model then says whether the stale word may reach the bus, and the bench compares rdata_drive and rdata_out against it every cycle. A second overlap is the processor strobe arriving while cs1_n is high in the middle of a burst. The bench judges this by the continuation data that keeps appearing on the bus.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Burst counter width is fixed by the two-bit wraparound sequence.
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ST_DESEL  = 2'd0,
        ST_PWAIT  = 2'd1,
        ST_ACTIVE = 2'd2
    } sbc_state_e;

    // Low address bits for a burst beat: linear adds, interleaved flips.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               linear
    );
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/sbc_ctrl_fsm.sv
module sbc_ctrl_fsm
    import sbc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             burst_adv_n,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic             load,
    output logic             step,
    output logic             op_wr,
    output logic             op_rd,
    output logic             desel,
    output logic             first_sel,
    output logic [LANES-1:0] wr_req,
    output logic [LANES-1:0] byte_we
);

    sbc_state_e state_q, state_d;
    logic selected, p_ok, strobe, cont;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    always_comb begin
        selected  = !cs1_n && cs2 && !cs3_n;
        p_ok      = !pstrb_n && !cs1_n;
        strobe    = p_ok || !cstrb_n;
        wr_req    = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_sel_n : '0);
        load      = 1'b0;
        cont      = 1'b0;
        desel     = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_DESEL: begin
                if (strobe) begin
                    if (selected) begin
                        load    = 1'b1;
                        state_d = p_ok ? ST_PWAIT : ST_ACTIVE;
                    end else begin
                        desel   = 1'b1;
                    end
                end
            end
            ST_PWAIT, ST_ACTIVE: begin
                if (strobe) begin
                    if (selected) begin
                        load    = 1'b1;
                        state_d = p_ok ? ST_PWAIT : ST_ACTIVE;
                    end else begin
                        desel   = 1'b1;
                        state_d = ST_DESEL;
                    end
                end else begin
                    cont    = 1'b1;
                    state_d = ST_ACTIVE;
                end
            end
            default: state_d = ST_DESEL;
        endcase
        op_wr     = ((load && !p_ok) || cont) && (wr_req != '0);
        byte_we   = op_wr ? wr_req : '0;
        op_rd     = (load || cont) && !op_wr;
        step      = cont && !burst_adv_n;
        first_sel = load && (state_q == ST_DESEL);
    end

    // R2: processor strobe alone, with cs1_n high, must not open or close anything
    p_pstrb_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n && cstrb_n) |-> (!load && !desel));

    // R4: the opening edge of a processor-strobe access never writes
    p_pfirst_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n && !cs1_n) |-> (byte_we == '0));

endmodule

// File: rtl/sbc_burst_addr.sv
module sbc_burst_addr
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] op_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q, cnt_nxt;

    assign cnt_nxt = cnt_q + {{(BURST_W-1){1'b0}}, step};

    always_comb begin
        if (load) op_addr = addr_in;
        else      op_addr = {base_q[ADDR_W-1:BURST_W],
                             burst_low(base_q[BURST_W-1:0], cnt_nxt, linear)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_nxt;
        end
    end

endmodule

// File: rtl/sbc_byte_array.sv
module sbc_byte_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          we,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/pburst_sram_ctrl.sv
module pburst_sram_ctrl #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pstrb_n,
    input  logic                    cstrb_n,
    input  logic                    burst_adv_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    burst_linear,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata_out,
    output logic                    rdata_drive
);

    localparam int WORD_W = LANES * LANE_W;

    logic              load, step, op_wr, op_rd, desel, first_sel;
    logic [LANES-1:0]  wr_req, byte_we;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] arr_rdata, rd_q, dout_q;
    logic              rd_v, vis_q;

    sbc_ctrl_fsm #(.LANES(LANES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pstrb_n    (pstrb_n),
        .cstrb_n    (cstrb_n),
        .burst_adv_n(burst_adv_n),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_sel_n (lane_sel_n),
        .load       (load),
        .step       (step),
        .op_wr      (op_wr),
        .op_rd      (op_rd),
        .desel      (desel),
        .first_sel  (first_sel),
        .wr_req     (wr_req),
        .byte_we    (byte_we)
    );

    sbc_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .linear (burst_linear),
        .addr_in(addr),
        .op_addr(op_addr)
    );

    sbc_byte_array #(
        .LANES (LANES),
        .LANE_W(LANE_W),
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (op_addr),
        .we   (byte_we),
        .wdata(wdata),
        .rdata(arr_rdata)
    );

    // Two register stages: array capture, then the output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            rd_v   <= 1'b0;
            dout_q <= '0;
            vis_q  <= 1'b0;
        end else begin
            if (op_rd) rd_q <= arr_rdata;
            rd_v   <= op_rd;
            dout_q <= rd_q;
            vis_q  <= rd_v && !op_wr && !desel;
        end
    end

    assign rdata_drive = vis_q && !out_en_n && (wr_req == '0);
    assign rdata_out   = rdata_drive ? dout_q : '0;

    // R9: first cycle after leaving deselect keeps the bus released
    p_first_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        first_sel |=> !rdata_drive);

    // R10: a deselecting edge releases the bus for the following cycle
    p_desel_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !rdata_drive);

    // R11: no drive in the cycle after an array write
    p_write_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we != '0) |=> !rdata_drive);

endmodule

// File: tb/pburst_sram_ctrl_tb_top.sv
`timescale 1ns/100ps
module pburst_sram_ctrl_tb_top;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DEPTH  = 16;
    localparam int AW     = 4;
    localparam int WW     = LANES * LANE_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             pstrb_n, cstrb_n, burst_adv_n, cs1_n, cs2, cs3_n;
    logic             wr_all_n, wr_byte_n, out_en_n, burst_linear;
    logic [LANES-1:0] lane_sel_n;
    logic [AW-1:0]    addr;
    logic [WW-1:0]    wdata, rdata_out;
    logic             rdata_drive;

    pburst_sram_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
        .burst_adv_n(burst_adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .burst_linear(burst_linear), .addr(addr),
        .wdata(wdata), .rdata_out(rdata_out), .rdata_drive(rdata_drive)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string phase  = "R12";

    // Behavioural reference state
    logic [WW-1:0] ref_mem [DEPTH];
    bit            m_active, m_rdv, m_vis;
    int            m_base, m_cnt;
    logic [WW-1:0] m_rdq, m_dout;

    function automatic logic [LANES-1:0] req_mask();
        if (!wr_all_n)  return '1;
        if (!wr_byte_n) return ~lane_sel_n;
        return '0;
    endfunction

    function automatic logic [WW-1:0] pat(int a);
        return {4{9'(a * 37 + 11)}} ^ 36'h0F0F3C3C5;
    endfunction

    task automatic check_out();
        bit exp_oe;
        exp_oe = m_vis && !out_en_n && (req_mask() == '0);
        checks++;
        if (rdata_drive !== exp_oe) begin
            errors++;
            $display("FAIL %s rdata_drive: actual %0b expected %0b", phase, rdata_drive, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (rdata_out !== m_dout) begin
                errors++;
                $display("FAIL %s rdata_out: actual %h expected %h", phase, rdata_out, m_dout);
            end
        end
    endtask

    task automatic model_edge();
        bit sel, peff, strobe, load, cont, wr, rd;
        logic [LANES-1:0] m;
        int nc, a;
        sel    = !cs1_n && cs2 && !cs3_n;
        peff   = !pstrb_n && !cs1_n;
        strobe = peff || !cstrb_n;
        m      = req_mask();
        load   = strobe && sel;
        cont   = m_active && !strobe;
        wr     = ((load && !peff) || cont) && (m != '0);
        rd     = (load || cont) && !wr;
        nc     = (m_cnt + ((cont && !burst_adv_n) ? 1 : 0)) % 4;
        if (load) a = int'(addr);
        else a = (m_base & ~3) | (burst_linear ? ((m_base + nc) % 4) : ((m_base % 4) ^ nc));
        m_vis  = m_rdv && !wr && !(strobe && !sel);
        m_dout = m_rdq;
        if (rd) m_rdq = ref_mem[a];
        m_rdv  = rd;
        if (wr)
            for (int i = 0; i < LANES; i++)
                if (m[i]) ref_mem[a][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
        if (load) begin
            m_base = int'(addr); m_cnt = 0; m_active = 1;
        end else if (cont) begin
            m_cnt = nc;
        end
        if (strobe && !sel) m_active = 0;
    endtask

    task automatic tick();
        #1 check_out();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        pstrb_n = 1; cstrb_n = 1; burst_adv_n = 1;
        cs1_n = 0; cs2 = 1; cs3_n = 0;
        wr_all_n = 1; wr_byte_n = 1; lane_sel_n = '1;
        out_en_n = 0; wdata = '0;
    endtask

    task automatic nop();
        idle_in(); tick();
    endtask

    task automatic c_read(int a);
        idle_in(); cstrb_n = 0; addr = 4'(a); tick();
    endtask

    task automatic c_write(int a, logic [WW-1:0] d, bit glob, logic [LANES-1:0] sel_n);
        idle_in(); cstrb_n = 0; addr = 4'(a); wdata = d;
        if (glob) wr_all_n = 0;
        else begin wr_byte_n = 0; lane_sel_n = sel_n; end
        tick();
    endtask

    task automatic deselect();
        idle_in(); cstrb_n = 0; cs2 = 0; tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        m_active = 0; m_rdv = 0; m_vis = 0; m_base = 0; m_cnt = 0;
        m_rdq = '0; m_dout = '0;
        idle_in(); addr = '0; burst_linear = 1; rst_n = 0;
        repeat (3) @(negedge clk);
        // R12: bus released in reset
        checks++;
        if (rdata_drive !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset drive: actual %0b expected 0", rdata_drive);
        end
        rst_n = 1;
        @(negedge clk);

        // R12: array reads zero after reset
        phase = "R12";
        c_read(5); c_read(12); nop(); nop(); deselect(); nop();

        // R5: controller-strobe global writes land on the opening edge
        phase = "R5";
        for (int a = 0; a < DEPTH; a++) c_write(a, pat(a), 1, '1);
        // R3: consecutive single reads
        phase = "R3";
        for (int a = 0; a < DEPTH; a++) c_read(a);
        nop(); nop();
        // R10: deselect right behind reads in flight
        phase = "R10";
        c_read(3); c_read(4); deselect(); nop(); nop();
        // R9: first read after deselect stays released one cycle
        phase = "R9";
        c_read(7); nop(); nop(); deselect();

        // R6: every lane-select combination, plus global override
        phase = "R6";
        for (int mk = 0; mk < 16; mk++) begin
            c_write(mk, {$urandom, $urandom}, 0, ~4'(mk));
            c_read(mk); nop(); nop();
        end
        idle_in(); cstrb_n = 0; addr = 4'd9; wdata = 36'h123456789;
        wr_all_n = 0; wr_byte_n = 0; lane_sel_n = 4'hE; tick();
        c_read(9); nop(); nop();

        // R7 / R8: bursts in both orders from every start offset
        phase = "R7";
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < 4; s++) begin
                burst_linear = lin[0];
                c_read(8 + s);
                for (int b = 0; b < 3; b++) begin
                    idle_in(); burst_adv_n = 0; tick();
                end
                phase = "R8";
                nop(); nop();
                phase = "R7";
                idle_in(); burst_adv_n = 0; tick();
                deselect(); nop();
            end
            // burst write with lane writes on continuation edges
            c_write(4, pat(40), 1, '1);
            for (int b = 0; b < 3; b++) begin
                idle_in(); burst_adv_n = 0; wr_all_n = 0; wdata = pat(41 + b); tick();
            end
            for (int a = 4; a < 8; a++) c_read(a);
            nop(); nop(); deselect();
        end

        // R4: processor-strobe write, first-edge write controls ignored
        phase = "R4";
        burst_linear = 1;
        deselect();
        idle_in(); pstrb_n = 0; addr = 4'd2; wr_all_n = 0; wdata = pat(99); tick();
        idle_in(); wr_byte_n = 0; lane_sel_n = 4'b0101; wdata = pat(77); tick();
        c_read(2); nop(); nop();
        c_read(6); c_read(6);
        idle_in(); pstrb_n = 0; addr = 4'd6; tick();
        idle_in(); wr_all_n = 0; wdata = pat(55); tick();
        c_read(6); nop(); nop();
        // R4: processor-strobe read with no write at second edge
        idle_in(); pstrb_n = 0; addr = 4'd11; tick();
        nop(); nop(); deselect();

        // R2: processor strobe with cs1_n high is ignored
        phase = "R2";
        idle_in(); pstrb_n = 0; cs1_n = 1; addr = 4'd3; tick();
        nop(); nop();
        c_read(13); nop();
        idle_in(); pstrb_n = 0; cs1_n = 1; addr = 4'd0; tick();
        nop(); nop(); deselect();

        // R1: each single chip select failing turns a strobe into deselect
        phase = "R1";
        c_read(1); c_read(2);
        idle_in(); cstrb_n = 0; cs3_n = 1; addr = 4'd5; tick();
        nop(); c_read(1);
        idle_in(); cstrb_n = 0; cs1_n = 1; addr = 4'd5; tick();
        nop(); c_read(1); nop();
        idle_in(); pstrb_n = 0; cs2 = 0; addr = 4'd5; tick();
        nop(); nop();

        // R11: write request and output enable against a pending read
        phase = "R11";
        c_read(10); c_read(11);
        idle_in(); wr_byte_n = 0; lane_sel_n = 4'b1110; wdata = pat(3); tick();
        nop(); nop();
        idle_in(); out_en_n = 1; tick();
        nop();
        idle_in(); wr_byte_n = 0; lane_sel_n = '1; tick();
        nop(); deselect();
        idle_in(); cs2 = 0; wr_all_n = 0; tick();
        nop();

        // Final sweep of the whole array
        phase = "R3";
        for (int a = 0; a < DEPTH; a++) c_read(a);
        nop(); nop(); deselect(); nop();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule